// File: doc/BRIEF.md
# Self-Test Loopback Guard

This block controls the internal self-test mode of a serial link module. When the host issues the arm command, the block routes the module's own transmit data back into its receiver. It also routes the transmitter's request line back into the ready input that the transmitter watches. While the mode is on, every external port is cut off. Values arriving on the serial pins and the front-panel port never reach the core, and every external output is driven low. This lets the host run a full write and read-back test over the host bus alone, with no cable and no peer.

Isolating the module is risky if it is left on by mistake, so the mode guards itself. A retriggerable countdown ends the mode after `TIMEOUT_CYC` clock cycles with no host command. Any host command strobe seen during the mode restarts the count. A separate drop command ends the mode on the next cycle, and the synchronous initialise strobe does the same. The command decoder and the serial line coding sit outside this block. Its inputs are single-cycle decoded strobes and plain link-level signals.

Top module: `loopback_guard`

## Requirements
- R1: After asynchronous reset, or one cycle after `init_clr` is high, `loop_active` is 0 and the timer is cleared; `init_clr` overrides every other strobe.
- R2: A `cmd_loop_on` strobe without `cmd_loop_off` or `init_clr` makes `loop_active` 1 from the next cycle; repeating it while the mode is on restarts the full interval.
- R3: A `cmd_loop_off` strobe makes `loop_active` 0 from the next cycle, and it wins over a simultaneous `cmd_loop_on`.
- R4: While `loop_active` is 1, `lnk_rx_data` equals `lnk_tx_data` and `lnk_peer_rdy` equals `lnk_tx_req`, in the same cycle.
- R5: While `loop_active` is 0, the block passes signals straight through: `lnk_rx_data`=`pin_rx_data`, `lnk_peer_rdy`=`pin_peer_req`, `pin_tx_data`=`lnk_tx_data`, `pin_rx_rdy`=`lnk_rx_rdy`, `lnk_fp_data`=`pin_fp_data`, `lnk_fp_clk`=`pin_fp_clk`, `pin_fp_on`=`lnk_fp_on` and `pin_fp_rd`=`lnk_fp_rd`.
- R6: While `loop_active` is 1, the values on `pin_rx_data`, `pin_peer_req`, `pin_fp_data` and `pin_fp_clk` have no effect: `lnk_fp_data` and `lnk_fp_clk` are 0, and the receive paths follow R4.
- R7: While `loop_active` is 1, `pin_tx_data`, `pin_rx_rdy`, `pin_fp_on` and every bit of `pin_fp_rd` are 0. The peer therefore never sees the module as ready.
- R8: With no host strobe, `loop_active` stays 1 for exactly `TIMEOUT_CYC` cycles after the cycle that sampled the last arm or retrigger, and then drops to 0.
- R9: A `cmd_any` strobe while `loop_active` is 1 restarts the interval of R8. While `loop_active` is 0, `cmd_any` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_clr | input | 1 | Crate initialise strobe, synchronous |
| cmd_loop_on | input | 1 | Arm/retrigger loopback strobe |
| cmd_loop_off | input | 1 | Immediate loopback drop strobe |
| cmd_any | input | 1 | Strobe for any host function command |
| lnk_tx_data | input | 1 | Serial transmit data from the core |
| lnk_tx_req | input | 1 | Transmit request from the core |
| lnk_rx_rdy | input | 1 | Receiver ready from the core |
| lnk_fp_on | input | 1 | Front-panel block-transfer ready from the core |
| lnk_fp_rd | input | RD_W | Front-panel readout word from the core |
| pin_rx_data | input | 1 | External serial receive data |
| pin_peer_req | input | 1 | External peer request |
| pin_fp_data | input | 1 | Front-panel block-transfer data |
| pin_fp_clk | input | 1 | Front-panel block-transfer clock |
| lnk_rx_data | output | 1 | Receive data to the core |
| lnk_peer_rdy | output | 1 | Peer-ready seen by the core transmitter |
| lnk_fp_data | output | 1 | Front-panel data to the core |
| lnk_fp_clk | output | 1 | Front-panel clock to the core |
| pin_tx_data | output | 1 | External serial transmit data |
| pin_rx_rdy | output | 1 | External receiver-ready output |
| pin_fp_on | output | 1 | External front-panel ready output |
| pin_fp_rd | output | RD_W | External front-panel readout word |
| loop_active | output | 1 | Loopback mode flag |

## Verification
Mode changes are registered, so the effect of every strobe shows on `loop_active` one clock after the edge that samples it. The path multiplexing and isolation are purely combinational from that flag, so they appear in the same cycle that the flag changes. The bench drives on the falling edge and samples just before the next falling edge. A strobe is therefore judged one cycle after it is applied, and a data pattern is judged within the cycle it is applied. For the timeout, the bench counts falling edges from the edge that took the last strobe. It expects the flag high on exactly `TIMEOUT_CYC` of them and low on the next.

// File: rtl/loopback_guard_pkg.sv
package loopback_guard_pkg;

  typedef enum logic {
    LG_IDLE = 1'b0,
    LG_LOOP = 1'b1
  } lg_state_e;

  typedef enum logic [1:0] {
    LG_REQ_NONE = 2'd0,
    LG_REQ_ARM  = 2'd1,
    LG_REQ_DROP = 2'd2
  } lg_req_e;

  function automatic lg_req_e lg_resolve(input logic init_s, input logic off_s,
                                         input logic on_s, input logic any_s,
                                         input logic in_loop);
    if (init_s || off_s)           return LG_REQ_DROP;
    else if (on_s)                 return LG_REQ_ARM;
    else if (any_s && in_loop)     return LG_REQ_ARM;
    else                           return LG_REQ_NONE;
  endfunction

endpackage

// File: rtl/lg_cmd_arb.sv
module lg_cmd_arb
  import loopback_guard_pkg::*;
(
  input  logic    init_clr,
  input  logic    cmd_loop_on,
  input  logic    cmd_loop_off,
  input  logic    cmd_any,
  input  logic    in_loop,
  output lg_req_e req
);

  always_comb begin
    req = lg_resolve(init_clr, cmd_loop_off, cmd_loop_on, cmd_any, in_loop);
  end

endmodule

// File: rtl/lg_timer.sv
module lg_timer #(
  parameter int unsigned TIMEOUT_CYC = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  input  logic run,
  output logic expired
);

  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] RELOAD = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clear) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (load) begin
      cnt_d  = RELOAD;
      cnt_en = 1'b1;
    end else if (run && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/lg_mode_fsm.sv
module lg_mode_fsm
  import loopback_guard_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  lg_req_e req,
  input  logic    expired,
  output logic    in_loop
);

  lg_state_e state_q;
  lg_state_e state_d;
  logic      state_en;

  always_comb begin
    state_d = state_q;
    unique case (req)
      LG_REQ_DROP: state_d = LG_IDLE;
      LG_REQ_ARM:  state_d = LG_LOOP;
      default: begin
        if ((state_q == LG_LOOP) && expired) state_d = LG_IDLE;
      end
    endcase
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LG_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign in_loop = (state_q == LG_LOOP);

endmodule

// File: rtl/lg_port_gate.sv
module lg_port_gate #(
  parameter int unsigned W = 1
) (
  input  logic         block,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar g = 0; g < W; g++) begin : g_lane
    assign dout[g] = din[g] & ~block;
  end

endmodule

// File: rtl/loopback_guard.sv
module loopback_guard
  import loopback_guard_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 20_000_000,
  parameter int unsigned RD_W        = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_clr,
  input  logic            cmd_loop_on,
  input  logic            cmd_loop_off,
  input  logic            cmd_any,
  input  logic            lnk_tx_data,
  input  logic            lnk_tx_req,
  input  logic            lnk_rx_rdy,
  input  logic            lnk_fp_on,
  input  logic [RD_W-1:0] lnk_fp_rd,
  input  logic            pin_rx_data,
  input  logic            pin_peer_req,
  input  logic            pin_fp_data,
  input  logic            pin_fp_clk,
  output logic            lnk_rx_data,
  output logic            lnk_peer_rdy,
  output logic            lnk_fp_data,
  output logic            lnk_fp_clk,
  output logic            pin_tx_data,
  output logic            pin_rx_rdy,
  output logic            pin_fp_on,
  output logic [RD_W-1:0] pin_fp_rd,
  output logic            loop_active
);

  localparam int unsigned OUT_W = RD_W + 3;

  lg_req_e req;
  logic    expired;
  logic    in_loop;

  lg_cmd_arb u_arb (
    .init_clr    (init_clr),
    .cmd_loop_on (cmd_loop_on),
    .cmd_loop_off(cmd_loop_off),
    .cmd_any     (cmd_any),
    .in_loop     (in_loop),
    .req         (req)
  );

  lg_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (req == LG_REQ_ARM),
    .clear  (req == LG_REQ_DROP),
    .run    (in_loop),
    .expired(expired)
  );

  lg_mode_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .expired(expired),
    .in_loop(in_loop)
  );

  // Outbound pins: all forced low during self test.
  logic [OUT_W-1:0] out_raw;
  logic [OUT_W-1:0] out_gated;
  assign out_raw = {lnk_fp_rd, lnk_fp_on, lnk_rx_rdy, lnk_tx_data};

  lg_port_gate #(.W(OUT_W)) u_gate_out (
    .block(in_loop),
    .din  (out_raw),
    .dout (out_gated)
  );

  assign pin_tx_data = out_gated[0];
  assign pin_rx_rdy  = out_gated[1];
  assign pin_fp_on   = out_gated[2];
  assign pin_fp_rd   = out_gated[OUT_W-1:3];

  // Front-panel inbound: ignored during self test.
  logic [1:0] fp_gated;
  lg_port_gate #(.W(2)) u_gate_fp (
    .block(in_loop),
    .din  ({pin_fp_clk, pin_fp_data}),
    .dout (fp_gated)
  );
  assign lnk_fp_data = fp_gated[0];
  assign lnk_fp_clk  = fp_gated[1];

  // Serial receive side: loop the transmitter back onto itself.
  assign lnk_rx_data  = in_loop ? lnk_tx_data : pin_rx_data;
  assign lnk_peer_rdy = in_loop ? lnk_tx_req  : pin_peer_req;

  assign loop_active = in_loop;

endmodule

// File: rtl/loopback_guard_chk.sv
module loopback_guard_chk #(
  parameter int unsigned TIMEOUT_CYC = 20_000_000,
  parameter int unsigned RD_W        = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            init_clr,
  input logic            cmd_loop_on,
  input logic            cmd_loop_off,
  input logic            cmd_any,
  input logic            lnk_tx_data,
  input logic            lnk_tx_req,
  input logic            pin_rx_data,
  input logic            lnk_rx_data,
  input logic            lnk_peer_rdy,
  input logic            lnk_fp_data,
  input logic            lnk_fp_clk,
  input logic            pin_tx_data,
  input logic            pin_rx_rdy,
  input logic            pin_fp_on,
  input logic [RD_W-1:0] pin_fp_rd,
  input logic            loop_active
);

  localparam int unsigned IW = $clog2(TIMEOUT_CYC + 2);

  logic [IW-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
    end else if (init_clr || cmd_loop_off) begin
      idle_q <= '0;
    end else if (cmd_loop_on || (cmd_any && loop_active)) begin
      idle_q <= IW'(1);
    end else if (loop_active) begin
      idle_q <= idle_q + 1'b1;
    end else begin
      idle_q <= '0;
    end
  end

  assert_init_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr |=> !loop_active);

  assert_arm_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_loop_on && !cmd_loop_off && !init_clr) |=> loop_active);

  assert_drop_exits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_loop_off |=> !loop_active);

  assert_loop_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    loop_active |-> (lnk_rx_data == lnk_tx_data) && (lnk_peer_rdy == lnk_tx_req));

  assert_pass_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_active |-> (lnk_rx_data == pin_rx_data));

  assert_fp_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    loop_active |-> !lnk_fp_data && !lnk_fp_clk);

  assert_pins_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    loop_active |-> !pin_tx_data && !pin_rx_rdy && !pin_fp_on && (pin_fp_rd == '0));

  assert_window_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_active |-> (idle_q <= IW'(TIMEOUT_CYC)));

  assert_no_early_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(loop_active) && !$past(init_clr) && !$past(cmd_loop_off))
      |-> ($past(idle_q) == IW'(TIMEOUT_CYC)));

  assert_any_no_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_active) |-> $past(cmd_loop_on));

endmodule

bind loopback_guard loopback_guard_chk #(
  .TIMEOUT_CYC(TIMEOUT_CYC),
  .RD_W       (RD_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .init_clr    (init_clr),
  .cmd_loop_on (cmd_loop_on),
  .cmd_loop_off(cmd_loop_off),
  .cmd_any     (cmd_any),
  .lnk_tx_data (lnk_tx_data),
  .lnk_tx_req  (lnk_tx_req),
  .pin_rx_data (pin_rx_data),
  .lnk_rx_data (lnk_rx_data),
  .lnk_peer_rdy(lnk_peer_rdy),
  .lnk_fp_data (lnk_fp_data),
  .lnk_fp_clk  (lnk_fp_clk),
  .pin_tx_data (pin_tx_data),
  .pin_rx_rdy  (pin_rx_rdy),
  .pin_fp_on   (pin_fp_on),
  .pin_fp_rd   (pin_fp_rd),
  .loop_active (loop_active)
);

// File: tb/tb_loopback_guard.sv
`timescale 1ns/1ps
module tb_loopback_guard;

  localparam int unsigned T    = 40;
  localparam int unsigned RD_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic init_clr, cmd_loop_on, cmd_loop_off, cmd_any;
  logic lnk_tx_data, lnk_tx_req, lnk_rx_rdy, lnk_fp_on;
  logic [RD_W-1:0] lnk_fp_rd;
  logic pin_rx_data, pin_peer_req, pin_fp_data, pin_fp_clk;
  logic lnk_rx_data, lnk_peer_rdy, lnk_fp_data, lnk_fp_clk;
  logic pin_tx_data, pin_rx_rdy, pin_fp_on;
  logic [RD_W-1:0] pin_fp_rd;
  logic loop_active;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  loopback_guard #(.TIMEOUT_CYC(T), .RD_W(RD_W)) dut (
    .clk(clk), .rst_n(rst_n), .init_clr(init_clr), .cmd_loop_on(cmd_loop_on),
    .cmd_loop_off(cmd_loop_off), .cmd_any(cmd_any), .lnk_tx_data(lnk_tx_data),
    .lnk_tx_req(lnk_tx_req), .lnk_rx_rdy(lnk_rx_rdy), .lnk_fp_on(lnk_fp_on),
    .lnk_fp_rd(lnk_fp_rd), .pin_rx_data(pin_rx_data), .pin_peer_req(pin_peer_req),
    .pin_fp_data(pin_fp_data), .pin_fp_clk(pin_fp_clk), .lnk_rx_data(lnk_rx_data),
    .lnk_peer_rdy(lnk_peer_rdy), .lnk_fp_data(lnk_fp_data), .lnk_fp_clk(lnk_fp_clk),
    .pin_tx_data(pin_tx_data), .pin_rx_rdy(pin_rx_rdy), .pin_fp_on(pin_fp_on),
    .pin_fp_rd(pin_fp_rd), .loop_active(loop_active)
  );

  // {mode, txd,txr,rrdy,prx,preq,fpd,fpc,fpon, lrx,lpeer,ptx,prrdy,lfpd,lfpc,pfpon}
  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    16'b0_00000000_0000000,
    16'b0_10101010_0111010,
    16'b0_01010101_1000101,
    16'b0_11111111_1111111,
    16'b1_00011111_0000000,
    16'b1_11111111_1100000,
    16'b1_10011111_1000000,
    16'b1_01000000_0100000,
    16'b1_11000000_1100000,
    16'b0_11000000_0010000
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: cmd_loop_on = 1'b1;
      1: cmd_loop_off = 1'b1;
      2: cmd_any = 1'b1;
      3: init_clr = 1'b1;
      4: begin cmd_loop_on = 1'b1; cmd_loop_off = 1'b1; end
      default: ;
    endcase
    @(negedge clk);
    cmd_loop_on = 1'b0; cmd_loop_off = 1'b0; cmd_any = 1'b0; init_clr = 1'b0;
  endtask

  // Called right after the strobe was sampled: expects exactly T active cycles.
  task automatic expect_window(input string req);
    int seen = 0;
    for (int i = 0; i < int'(T); i++) begin
      if (loop_active) seen++;
      @(negedge clk);
    end
    check(seen == int'(T), req, seen, T);
    check(loop_active == 1'b0, req, loop_active, 0);
  endtask

  initial begin
    #(200_000 * 10);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    init_clr = 0; cmd_loop_on = 0; cmd_loop_off = 0; cmd_any = 0;
    lnk_tx_data = 1; lnk_tx_req = 0; lnk_rx_rdy = 1; lnk_fp_on = 1;
    lnk_fp_rd = 16'hA5C3;
    pin_rx_data = 0; pin_peer_req = 1; pin_fp_data = 1; pin_fp_clk = 0;
    repeat (3) @(negedge clk);
    // R1: reset state, pass-through
    check(loop_active == 1'b0, "R1 reset flag", loop_active, 0);
    check(pin_fp_rd == 16'hA5C3, "R1/R5 reset readout passes", pin_fp_rd, 16'hA5C3);
    rst_n = 1'b1;
    @(negedge clk);

    // Table of path patterns in both modes (R4 R5 R6 R7)
    for (int v = 0; v < NV; v++) begin
      logic [15:0] e;
      e = VEC[v];
      if (e[15]) pulse(0);
      else if (loop_active) pulse(1);
      {lnk_tx_data, lnk_tx_req, lnk_rx_rdy, pin_rx_data, pin_peer_req,
       pin_fp_data, pin_fp_clk, lnk_fp_on} = e[14:7];
      lnk_fp_rd = 16'(16'h1234 * (v + 1));
      #1;
      check({lnk_rx_data, lnk_peer_rdy, pin_tx_data, pin_rx_rdy, lnk_fp_data,
             lnk_fp_clk, pin_fp_on} == e[6:0], e[15] ? "R4/R6/R7 loop vector" : "R5 pass vector",
            {lnk_rx_data, lnk_peer_rdy, pin_tx_data, pin_rx_rdy, lnk_fp_data,
             lnk_fp_clk, pin_fp_on}, e[6:0]);
      check(pin_fp_rd == (e[15] ? 16'h0 : lnk_fp_rd), "R7/R5 readout word",
            pin_fp_rd, e[15] ? 0 : lnk_fp_rd);
    end

    // R3: drop ends the mode after one cycle
    pulse(0);
    pulse(1);
    check(loop_active == 1'b0, "R3 drop", loop_active, 0);

    // R3: drop wins over simultaneous arm
    pulse(4);
    check(loop_active == 1'b0, "R3 drop priority", loop_active, 0);

    // R9: cmd_any while idle has no effect
    lnk_tx_data = 1; pin_rx_data = 0;
    pulse(2);
    #1;
    check(loop_active == 1'b0, "R9 idle any ignored", loop_active, 0);
    check(pin_tx_data == 1'b1 && lnk_rx_data == 1'b0, "R9 idle any paths",
          {pin_tx_data, lnk_rx_data}, 2'b10);

    // R2/R8: arm then exact timeout
    pulse(0);
    check(loop_active == 1'b1, "R2 arm latency", loop_active, 1);
    expect_window("R8 timeout");

    // R9: host command retriggers mid-window
    pulse(0);
    repeat (T / 2) @(negedge clk);
    pulse(2);
    expect_window("R9 retrigger");

    // R2: arm again while active restarts the window
    pulse(0);
    repeat (T - 5) @(negedge clk);
    pulse(0);
    expect_window("R2 rearm");

    // R1: init clears at once, even with arm present
    pulse(0);
    @(negedge clk);
    init_clr = 1'b1; cmd_loop_on = 1'b1;
    @(negedge clk);
    init_clr = 1'b0; cmd_loop_on = 1'b0;
    check(loop_active == 1'b0, "R1 init clears", loop_active, 0);
    repeat (T + 2) @(negedge clk);
    check(loop_active == 1'b0, "R1 stays idle", loop_active, 0);

    // R1: async reset while active
    pulse(0);
    rst_n = 1'b0;
    #1;
    check(loop_active == 1'b0, "R1 async reset", loop_active, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule